// File: doc/BRIEF.md
# Core-local timer and software interrupt unit

This block sits next to a processor core and raises its two machine-level local interrupt requests. It holds a software-interrupt flag, a 64-bit time counter, a 64-bit cycle counter and a 64-bit timer compare value. Software sets and clears the software-interrupt flag and reprograms the compare value through a store port. Each store carries an address, a byte width and write data. The port answers in the same cycle with either an OK or an access-fault indication.

A tick input advances both counters together. On every tick the timer request is recomputed from scratch. It is raised only while the compare value is nonzero and strictly below the new time count. Between ticks the timer request holds its value.

Store addresses are decoded relative to a base address parameter. Only two offsets are mapped, and each accepts only certain widths.

Top module: `core_timer_unit`

## Requirements
- R1: After reset the time count, the cycle count and the compare value are zero, and `msip_pending` and `mtip_pending` are low.
- R2: A store at offset 0x0000 with a width of 4 or 8 bytes is answered with `st_ok` high and `st_fault` low. From the next clock edge, `msip_pending` equals bit 0 of `st_wdata`.
- R3: A store at offset 0x4000 with a width of 8 bytes is answered with `st_ok`. It loads all 64 bits of `st_wdata` into the compare value.
- R4: Any other store raises `st_fault` for that cycle and leaves `st_ok` low. This covers every other offset, and a width of 0, 1, 2, 3, 5, 6 or 7 bytes at offset 0x0000. At offset 0x4000 every width except 8 faults. A faulting store changes neither the software flag nor the compare value. With `st_valid` low, both response outputs are low.
- R5: Each cycle with `tick` high adds one to both the time count and the cycle count. Without a tick, both hold their values.
- R6: On a tick, `mtip_pending` becomes 1 when the compare value is nonzero and unsigned-less-than the incremented time count. Otherwise it becomes 0. Without a tick it holds.
- R7: While the compare value is zero, a tick always drives `mtip_pending` to 0, whatever the time count is.
- R8: A store and a tick in the same cycle are both applied. The tick's timer evaluation uses the compare value held before that store.
- R9: The offset is the store address minus the `BASE_ADDR` parameter, computed modulo 2^ADDR_W. Addresses below the base therefore wrap to large offsets and fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store strobe |
| st_addr | input | ADDR_W | Store address (absolute) |
| st_size | input | 4 | Store width in bytes |
| st_wdata | input | 64 | Store data |
| st_ok | output | 1 | Store accepted (same cycle as strobe) |
| st_fault | output | 1 | Store access fault (same cycle as strobe) |
| tick | input | 1 | Advance counters by one |
| time_count | output | 64 | Current time count |
| cycle_count | output | 64 | Current cycle count |
| msip_pending | output | 1 | Software interrupt request |
| mtip_pending | output | 1 | Timer interrupt request |

## Verification
The decoder is swept over every width from 0 to 8 at six offsets: both mapped slots, their neighbours, an unmapped far offset, and an address below the base. This sweep separates the width rules of the two slots from plain offset matching. The compare path is tried with a zero compare value, with compare values equal to and just below the running time, and with a value whose upper word is nonzero. These cases separate strict from non-strict comparison, expose a disabled timer, and catch truncation of the 64-bit load. Stores issued in the same cycle as a tick, together with intervals of idle cycles, show whether the timer uses the old compare value and whether it holds between ticks.

// File: rtl/ctu_pkg.sv
package ctu_pkg;
    localparam int CNT_W  = 64;
    localparam int SIZE_W = 4;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_SOFT = 2'd1,
        TGT_CMP  = 2'd2
    } tgt_e;

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             msip;
        logic             mtip;
    } irq_state_t;
endpackage

// File: rtl/ctu_store_decode.sv
module ctu_store_decode
    import ctu_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0200_0000,
    parameter logic [31:0] SOFT_OFS  = 32'h0000_0000,
    parameter logic [31:0] CMP_OFS   = 32'h0000_4000
) (
    input  logic              valid,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output tgt_e              tgt,
    output logic              ok,
    output logic              fault
);
    localparam logic [ADDR_W-1:0] BASE_L = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] SOFT_L = ADDR_W'(SOFT_OFS);
    localparam logic [ADDR_W-1:0] CMP_L  = ADDR_W'(CMP_OFS);

    logic [ADDR_W-1:0] offset;
    logic              size_soft_ok;
    logic              size_cmp_ok;

    always_comb begin
        offset       = addr - BASE_L;
        size_soft_ok = (size == SIZE_W'(4)) || (size == SIZE_W'(8));
        size_cmp_ok  = (size == SIZE_W'(8));
        tgt          = TGT_NONE;
        if (offset == SOFT_L && size_soft_ok) begin
            tgt = TGT_SOFT;
        end else if (offset == CMP_L && size_cmp_ok) begin
            tgt = TGT_CMP;
        end
        ok    = valid && (tgt != TGT_NONE);
        fault = valid && (tgt == TGT_NONE);
    end
endmodule

// File: rtl/ctu_counter.sv
module ctu_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic [W-1:0] count_inc
);
    logic [W-1:0] count_d;
    logic [W-1:0] count_q;

    always_comb begin
        count_inc = count_q + W'(1);
        count_d   = tick ? count_inc : count_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;
endmodule

// File: rtl/ctu_cmp_eval.sv
module ctu_cmp_eval #(
    parameter int W = 64
) (
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] time_next,
    output logic         fire
);
    logic enabled;
    logic below;

    always_comb begin
        enabled = (cmp != '0);
        below   = (cmp < time_next);
        fire    = enabled && below;
    end
endmodule

// File: rtl/core_timer_unit.sv
module core_timer_unit
    import ctu_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0200_0000,
    parameter logic [31:0] SOFT_OFS  = 32'h0000_0000,
    parameter logic [31:0] CMP_OFS   = 32'h0000_4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [3:0]        st_size,
    input  logic [63:0]       st_wdata,
    output logic              st_ok,
    output logic              st_fault,
    input  logic              tick,
    output logic [63:0]       time_count,
    output logic [63:0]       cycle_count,
    output logic              msip_pending,
    output logic              mtip_pending
);
    localparam int NUM_CNT = 2;
    localparam int IDX_TIME  = 0;
    localparam int IDX_CYCLE = 1;

    tgt_e             tgt;
    logic [CNT_W-1:0] cnt_val [NUM_CNT];
    logic [CNT_W-1:0] cnt_inc [NUM_CNT];
    logic             fire;
    irq_state_t       state_d;
    irq_state_t       state_q;
    logic [CNT_W-1:0] cmp_now;

    ctu_store_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .SOFT_OFS  (SOFT_OFS),
        .CMP_OFS   (CMP_OFS)
    ) u_decode (
        .valid (st_valid),
        .addr  (st_addr),
        .size  (st_size),
        .tgt   (tgt),
        .ok    (st_ok),
        .fault (st_fault)
    );

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        ctu_counter #(.W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .count     (cnt_val[gi]),
            .count_inc (cnt_inc[gi])
        );
    end

    ctu_cmp_eval #(.W(CNT_W)) u_eval (
        .cmp       (state_q.cmp),
        .time_next (cnt_inc[IDX_TIME]),
        .fire      (fire)
    );

    always_comb begin
        state_d = state_q;
        if (tick) begin
            state_d.mtip = fire;
        end
        if (st_ok) begin
            if (tgt == TGT_SOFT) begin
                state_d.msip = st_wdata[0];
            end
            if (tgt == TGT_CMP) begin
                state_d.cmp = st_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign cmp_now      = state_q.cmp;
    assign time_count   = cnt_val[IDX_TIME];
    assign cycle_count  = cnt_val[IDX_CYCLE];
    assign msip_pending = state_q.msip;
    assign mtip_pending = state_q.mtip;
endmodule

// File: rtl/core_timer_unit_chk.sv
module core_timer_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        st_valid,
    input logic        st_ok,
    input logic        st_fault,
    input logic        tick,
    input logic [63:0] time_count,
    input logic [63:0] cycle_count,
    input logic        msip_pending,
    input logic        mtip_pending,
    input logic [63:0] cmp_now
);
    assert_resp_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_ok != st_fault));

    assert_resp_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |-> (!st_ok && !st_fault));

    assert_fault_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_fault |=> ($stable(msip_pending) && $stable(cmp_now)));

    assert_tick_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (time_count == $past(time_count) + 64'd1));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(time_count) && $stable(cycle_count)));

    assert_counters_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
        time_count == cycle_count);

    assert_mtip_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(mtip_pending));

    assert_zero_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cmp_now == 64'd0) |=> !mtip_pending);
endmodule

bind core_timer_unit core_timer_unit_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_valid     (st_valid),
    .st_ok        (st_ok),
    .st_fault     (st_fault),
    .tick         (tick),
    .time_count   (time_count),
    .cycle_count  (cycle_count),
    .msip_pending (msip_pending),
    .mtip_pending (mtip_pending),
    .cmp_now      (cmp_now)
);

// File: tb/core_timer_unit_tb.sv
module core_timer_unit_tb;
    localparam logic [31:0] BASE = 32'h0200_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic [3:0]  st_size = '0;
    logic [63:0] st_wdata = '0;
    logic        tick = 1'b0;
    logic        st_ok, st_fault;
    logic [63:0] time_count, cycle_count;
    logic        msip_pending, mtip_pending;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_time = '0;
    logic [63:0] m_cmp  = '0;
    logic        m_msip = 1'b0;
    logic        m_mtip = 1'b0;

    always #4 clk = ~clk;

    core_timer_unit u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_size(st_size), .st_wdata(st_wdata), .st_ok(st_ok), .st_fault(st_fault),
        .tick(tick), .time_count(time_count), .cycle_count(cycle_count),
        .msip_pending(msip_pending), .mtip_pending(mtip_pending)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check response, update model at edge, check outputs.
    task automatic cyc(input logic v, input logic [31:0] a, input logic [3:0] sz,
                       input logic [63:0] d, input logic tk, input string req);
        logic [31:0] off;
        logic        e_soft, e_cmp, e_ok;
        @(negedge clk);
        st_valid = v; st_addr = a; st_size = sz; st_wdata = d; tick = tk;
        off    = a - BASE;
        e_soft = (off == 32'h0) && (sz == 4'd4 || sz == 4'd8);
        e_cmp  = (off == 32'h4000) && (sz == 4'd8);
        e_ok   = v && (e_soft || e_cmp);
        #1;
        chk({req, " ok"}, {63'd0, st_ok}, {63'd0, e_ok});
        chk({req, " fault"}, {63'd0, st_fault}, {63'd0, v && !e_ok});
        @(posedge clk);
        if (tk) begin
            m_time = m_time + 64'd1;
            m_mtip = (m_cmp != 64'd0) && (m_cmp < m_time);
        end
        if (e_ok && e_soft) m_msip = d[0];
        if (e_ok && e_cmp)  m_cmp  = d;
        #1;
        st_valid = 1'b0; tick = 1'b0;
        chk("R5 time", time_count, m_time);
        chk("R5 cycle", cycle_count, m_time);
        chk({req, " msip"}, {63'd0, msip_pending}, {63'd0, m_msip});
        chk({req, " mtip"}, {63'd0, mtip_pending}, {63'd0, m_mtip});
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] offs [6];
        offs[0] = 32'h0;    offs[1] = 32'h4000; offs[2] = 32'h4;
        offs[3] = 32'h3FF8; offs[4] = 32'h8000; offs[5] = 32'hFFFF_FFF0;

        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk("R1 time", time_count, 64'd0);
        chk("R1 cycle", cycle_count, 64'd0);
        chk("R1 msip", {63'd0, msip_pending}, 64'd0);
        chk("R1 mtip", {63'd0, mtip_pending}, 64'd0);

        // R7: zero compare keeps timer low across ticks
        for (int i = 0; i < 5; i++) cyc(1'b0, 32'h0, 4'd0, 64'd0, 1'b1, "R7");

        // R2 R3 R4 R9: width/offset sweep; data alternates bit 0
        for (int o = 0; o < 6; o++) begin
            for (int s = 0; s <= 8; s++) begin
                cyc(1'b1, BASE + offs[o], 4'(s), {32'hA5A5_0000, 31'd0, 1'(s % 2 == 0)},
                    1'b0, "R2/R3/R4/R9 sweep");
                cyc(1'b0, BASE + offs[o], 4'(s), 64'd0, 1'b1, "R6 after sweep");
            end
        end

        // R2: 4-byte store sets then 8-byte store clears
        cyc(1'b1, BASE, 4'd4, 64'hFFFF_FFFF_0000_0001, 1'b0, "R2 set");
        cyc(1'b1, BASE, 4'd8, 64'h0000_0001_0000_0000, 1'b0, "R2 clear");

        // R6: compare relative to current time, strict-less check
        for (int c = -2; c <= 3; c++) begin
            cyc(1'b1, BASE + 32'h4000, 4'd8, m_time + 64'(c), 1'b0, "R6 load");
            for (int t = 0; t < 5; t++) cyc(1'b0, 32'h0, 4'd0, 64'd0, 1'b1, "R6 tick");
            for (int t = 0; t < 2; t++) cyc(1'b0, 32'h0, 4'd0, 64'd0, 1'b0, "R6 hold");
        end

        // R3: upper word kept -> huge compare never fires
        cyc(1'b1, BASE + 32'h4000, 4'd8, 64'h0000_0001_0000_0002, 1'b0, "R3 wide");
        for (int t = 0; t < 4; t++) cyc(1'b0, 32'h0, 4'd0, 64'd0, 1'b1, "R3 wide tick");

        // R4: 4-byte store to compare faults and leaves the old value
        cyc(1'b1, BASE + 32'h4000, 4'd8, 64'd3, 1'b1, "R8 store+tick");
        cyc(1'b1, BASE + 32'h4000, 4'd4, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, "R4 narrow cmp");
        cyc(1'b0, 32'h0, 4'd0, 64'd0, 1'b1, "R4 cmp kept");

        // R8: same-cycle store uses old compare (3 fires), new zero then disables
        cyc(1'b1, BASE + 32'h4000, 4'd8, 64'd0, 1'b1, "R8 old cmp used");
        chk("R8 old cmp fires", {63'd0, mtip_pending}, 64'd1);
        cyc(1'b0, 32'h0, 4'd0, 64'd0, 1'b1, "R8 new cmp applied");
        chk("R7 zero cmp low", {63'd0, mtip_pending}, 64'd0);
        // R8: old zero compare, new small value: tick still low, next tick high
        cyc(1'b1, BASE + 32'h4000, 4'd8, 64'd1, 1'b1, "R8 old zero");
        chk("R8 old zero low", {63'd0, mtip_pending}, 64'd0);
        cyc(1'b0, 32'h0, 4'd0, 64'd0, 1'b1, "R8 then fire");
        chk("R8 fires", {63'd0, mtip_pending}, 64'd1);

        // R1: reset again clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_time = '0; m_cmp = '0; m_msip = 1'b0; m_mtip = 1'b0;
        chk("R1 re-reset time", time_count, 64'd0);
        chk("R1 re-reset mtip", {63'd0, mtip_pending}, 64'd0);
        cyc(1'b0, 32'h0, 4'd0, 64'd0, 1'b1, "R7 after reset");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule